// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Address Filtering

This block is a full-duplex asynchronous serial port that runs from the peripheral clock. A 16-bit divisor sets a 16x oversampling tick. A set of static configuration inputs selects the character format: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. An optional ninth bit marks a frame as an address frame. This ninth bit lets several stations share one multidrop line.

The transmit side and the receive side each keep a holding register next to the shift register. While one character is on the wire, the host can queue the next one, and it can leave one received character waiting. In address mode the receiver discards data frames until it sees an address frame that matches its station address. It delivers that address frame with a flag. It then delivers the data frames that follow until a non-matching address frame arrives.

Each side raises its own interrupt request, and each request has its own mask. The configuration inputs must only change while both directions are idle.

Top module: `mdrop_uart`

## Requirements
- R1: Every bit on `txd` lasts exactly 16*(cfg_div+1) clock cycles, with `cfg_div` from 0 to 65535.
- R2: The line idles high. A frame starts with one low start bit, followed by the data bits least-significant first. `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Received data bits above the selected width read as zero in `rx_data`.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits and, in address mode, the address bit. The parity bit makes the count of ones over the data bits, the address bit and itself even when `cfg_par_odd` is 0, and odd when it is 1.
- R4: When `cfg_two_stop` is 1, the transmitter sends two high stop bits, and otherwise one. The receiver samples only the first stop bit.
- R5: When `cfg_addr_mode` is 1, a ninth bit follows the last data bit and comes before parity. The transmitter sends `tx_addr` in this bit. A value of 1 marks an address frame.
- R6: A `tx_wr` pulse while `tx_full` is 0 queues `tx_data`. A `tx_wr` pulse while `tx_full` is 1 is ignored and never reaches the line. Queued characters leave in the order they were written.
- R7: The receiver accepts a start bit only if the line is still low 8 oversample ticks after the falling edge. A shorter low pulse produces no character. The receiver samples each later bit every 16 ticks after that point.
- R8: A received character sets `rx_valid` and waits in the holding register until a `rx_rd` pulse clears it. If another character completes while `rx_valid` is 1, `rx_ovr` is set and the waiting character is kept. A `rx_rd` pulse also clears `rx_ovr`.
- R9: `rx_perr` flags a parity mismatch and `rx_ferr` flags a low first stop bit. Both flags belong to the character in the holding register.
- R10: In address mode, an address frame equal to `cfg_station` is delivered with `rx_is_addr` set to 1, and the data frames after it are delivered with `rx_is_addr` at 0. A non-matching address frame is dropped, and so is every data frame after it. After reset, data frames are dropped until a matching address frame arrives.
- R11: `irq_tx` is high while `tx_full` is 0 and `int_mask_tx` is 0. `irq_rx` is high while `rx_valid` or `rx_ovr` is 1 and `int_mask_rx` is 0.
- R12: After reset, `txd` is 1 and `tx_full`, `rx_valid` and `rx_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 16 | Oversample tick period minus one, in clocks |
| cfg_len | input | 2 | Data width code: 0 to 3 selects 5 to 8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Transmit two stop bits |
| cfg_addr_mode | input | 1 | Ninth address-marker bit and receive filtering |
| cfg_station | input | 8 | Own station address |
| int_mask_tx | input | 1 | Masks the transmit interrupt |
| int_mask_rx | input | 1 | Masks the receive interrupt |
| tx_wr | input | 1 | Write pulse for the transmit holding register |
| tx_data | input | 8 | Character to send |
| tx_addr | input | 1 | Address-marker value to send with the character |
| tx_full | output | 1 | Transmit holding register occupied |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read pulse that frees the receive holding register |
| rx_valid | output | 1 | Receive holding register occupied |
| rx_data | output | 8 | Received character |
| rx_is_addr | output | 1 | Received character was an address frame |
| rx_perr | output | 1 | Parity error on the held character |
| rx_ferr | output | 1 | Framing error on the held character |
| rx_ovr | output | 1 | Sticky overrun |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
A transmitted start bit begins on the clock edge after a queued character is loaded into the shifter. The bench therefore measures the low run of the start bit in clock cycles and samples every later bit at its midpoint, 16*(cfg_div+1) cycles apart. The receiver settles a character at the middle of the first stop bit, after a two-flop input synchroniser and the 8-tick start confirmation. The bench inspects the receive outputs only after it has driven the whole frame plus one idle bit, so the result is due well before the check. The interrupt outputs depend only on the holding flags and the masks, with no register between them. The bench compares them against its own model a quarter period after every rising edge, clear of the falling edge where it drives inputs.

// File: rtl/mdrop_uart.sv
module mdrop_uart #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic             cfg_addr_mode,
  input  logic [7:0]       cfg_station,
  input  logic             int_mask_tx,
  input  logic             int_mask_rx,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             tx_addr,
  output logic             tx_full,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_rd,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_is_addr,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr,
  output logic             irq_tx,
  output logic             irq_rx
);
  localparam int FRM_W = 12;
  localparam int IDX_W = $clog2(FRM_W + 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  logic [3:0] nd;
  logic [7:0] dmask;
  assign nd    = 4'd5 + {2'b00, cfg_len};
  assign dmask = 8'hFF >> (4'd8 - nd);

  // transmit side
  logic [7:0]       thr;
  logic             thr_a, thr_full, tx_busy, txd_r;
  logic [FRM_W-1:0] tx_sh, tx_pay;
  logic [IDX_W-1:0] tx_left, tx_len;
  logic [3:0]       tx_os, tp;
  logic [DIV_W-1:0] tx_pre;
  logic             tx_tick;

  assign tx_tick = (tx_pre == cfg_div);

  always_comb begin
    tx_pay = '1;
    tp     = nd;
    for (int i = 0; i < 8; i++)
      if (4'(i) < nd) tx_pay[i] = thr[i];
    if (cfg_addr_mode) begin
      tx_pay[tp] = thr_a;
      tp = tp + 4'd1;
    end
    if (cfg_par_en) begin
      tx_pay[tp] = ^(thr & dmask) ^ (cfg_addr_mode & thr_a) ^ cfg_par_odd;
      tp = tp + 4'd1;
    end
    tx_len = tp + 4'd1 + {3'b000, cfg_two_stop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_a    <= 1'b0;
      thr_full <= 1'b0;
      tx_busy  <= 1'b0;
      txd_r    <= 1'b1;
      tx_sh    <= '1;
      tx_left  <= '0;
      tx_os    <= '0;
      tx_pre   <= '0;
    end else begin
      if (tx_wr && !thr_full) begin
        thr      <= tx_data;
        thr_a    <= tx_addr;
        thr_full <= 1'b1;
      end
      if (!tx_busy) begin
        tx_pre <= '0;
        if (thr_full) begin
          tx_busy  <= 1'b1;
          tx_sh    <= tx_pay;
          tx_left  <= tx_len;
          tx_os    <= '0;
          txd_r    <= 1'b0;
          thr_full <= 1'b0;
        end
      end else begin
        tx_pre <= tx_tick ? '0 : tx_pre + 1'b1;
        if (tx_tick) begin
          tx_os <= tx_os + 4'd1;
          if (tx_os == 4'd15) begin
            if (tx_left == '0) begin
              tx_busy <= 1'b0;
              txd_r   <= 1'b1;
            end else begin
              txd_r   <= tx_sh[0];
              tx_sh   <= {1'b1, tx_sh[FRM_W-1:1]};
              tx_left <= tx_left - 1'b1;
            end
          end
        end
      end
    end
  end

  // receive side
  logic             rx_m, rxs, listen;
  rx_st_t           rx_st;
  logic [DIV_W-1:0] rx_pre;
  logic [3:0]       rx_os;
  logic [IDX_W-1:0] rx_idx, rx_stop_pos;
  logic [FRM_W-1:0] rx_sh;
  logic [7:0]       rbr, rx_d;
  logic             rbr_a, rbr_pe, rbr_fe, rx_full, rx_ovr_r;
  logic             rx_tick, rx_done, rx_a, rx_pb, rx_pe_now, rx_take;

  assign rx_tick     = (rx_pre == cfg_div);
  assign rx_stop_pos = nd + {3'b000, cfg_addr_mode} + {3'b000, cfg_par_en};
  assign rx_d        = rx_sh[7:0] & dmask;
  assign rx_a        = cfg_addr_mode & rx_sh[nd];
  assign rx_pb       = rx_sh[nd + {3'b000, cfg_addr_mode}];
  assign rx_pe_now   = cfg_par_en & (^rx_d ^ rx_a ^ rx_pb ^ cfg_par_odd);
  assign rx_take     = !cfg_addr_mode || (rx_a ? (rx_d == cfg_station) : listen);
  assign rx_done     = (rx_st == RX_BITS) && rx_tick && (rx_os == 4'd15) &&
                       (rx_idx == rx_stop_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m     <= 1'b1;
      rxs      <= 1'b1;
      rx_st    <= RX_IDLE;
      rx_pre   <= '0;
      rx_os    <= '0;
      rx_idx   <= '0;
      rx_sh    <= '0;
      listen   <= 1'b0;
      rbr      <= '0;
      rbr_a    <= 1'b0;
      rbr_pe   <= 1'b0;
      rbr_fe   <= 1'b0;
      rx_full  <= 1'b0;
      rx_ovr_r <= 1'b0;
    end else begin
      rx_m <= rxd;
      rxs  <= rx_m;
      if (rx_rd) begin
        rx_full  <= 1'b0;
        rx_ovr_r <= 1'b0;
      end
      if (rx_st == RX_IDLE) begin
        rx_pre <= '0;
        rx_os  <= '0;
        if (!rxs) rx_st <= RX_START;
      end else begin
        rx_pre <= rx_tick ? '0 : rx_pre + 1'b1;
        if (rx_tick) rx_os <= rx_os + 4'd1;
        if (rx_st == RX_START) begin
          if (rx_tick && rx_os == 4'd7) begin
            if (rxs) begin
              rx_st <= RX_IDLE;
            end else begin
              rx_st  <= RX_BITS;
              rx_os  <= '0;
              rx_idx <= '0;
            end
          end
        end else if (rx_tick && rx_os == 4'd15) begin
          rx_sh[rx_idx] <= rxs;
          rx_idx        <= rx_idx + 1'b1;
        end
      end
      if (rx_done) begin
        rx_st <= RX_IDLE;
        if (cfg_addr_mode && rx_a) listen <= (rx_d == cfg_station);
        if (rx_take) begin
          if (rx_full && !rx_rd) begin
            rx_ovr_r <= 1'b1;
          end else begin
            rbr     <= rx_d;
            rbr_a   <= rx_a;
            rbr_pe  <= rx_pe_now;
            rbr_fe  <= !rxs;
            rx_full <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_full    = thr_full;
  assign txd        = txd_r;
  assign rx_valid   = rx_full;
  assign rx_data    = rbr;
  assign rx_is_addr = rbr_a;
  assign rx_perr    = rbr_pe;
  assign rx_ferr    = rbr_fe;
  assign rx_ovr     = rx_ovr_r;
  assign irq_tx     = !thr_full && !int_mask_tx;
  assign irq_rx     = (rx_full || rx_ovr_r) && !int_mask_rx;
endmodule

// File: rtl/mdrop_uart_chk.sv
module mdrop_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_full,
  input logic txd,
  input logic tx_busy,
  input logic rx_rd,
  input logic rx_valid,
  input logic rx_ovr,
  input logic rx_done,
  input logic int_mask_tx,
  input logic int_mask_rx,
  input logic irq_tx,
  input logic irq_rx
);
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_full_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_full) |-> $past(tx_wr));

  p_rd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !rx_done) |=> !rx_valid);

  p_valid_falls_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_valid) |-> $past(rx_rd));

  p_ovr_after_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> $past(rx_valid));

  p_tx_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int_mask_tx |-> !irq_tx);

  p_rx_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int_mask_rx |-> !irq_rx);
endmodule

bind mdrop_uart mdrop_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_full(tx_full), .txd(txd),
  .tx_busy(tx_busy), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_ovr(rx_ovr),
  .rx_done(rx_done), .int_mask_tx(int_mask_tx), .int_mask_rx(int_mask_rx),
  .irq_tx(irq_tx), .irq_rx(irq_rx)
);

// File: tb/mdrop_uart_tb.sv
module mdrop_uart_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd2;
  logic [1:0]  cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_addr_mode = 0;
  logic [7:0] cfg_station = 8'h42;
  logic int_mask_tx = 0, int_mask_rx = 0;
  logic tx_wr = 0, tx_addr = 0, rxd = 1, rx_rd = 0;
  logic [7:0] tx_data = '0;
  logic tx_full, txd, rx_valid, rx_is_addr, rx_perr, rx_ferr, rx_ovr, irq_tx, irq_rx;
  logic [7:0] rx_data;

  int n_chk = 0, n_err = 0, P = 48;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mdrop_uart u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cfg_addr_mode(cfg_addr_mode), .cfg_station(cfg_station),
    .int_mask_tx(int_mask_tx), .int_mask_rx(int_mask_rx),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_addr(tx_addr), .tx_full(tx_full), .txd(txd),
    .rxd(rxd), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_is_addr(rx_is_addr), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // model of the interrupt requests, compared every cycle
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R11 irq_tx", irq_tx, !tx_full && !int_mask_tx);
      chk("R11 irq_rx", irq_rx, (rx_valid || rx_ovr) && !int_mask_rx);
    end
  end

  task automatic setcfg(input int dv, input int ln, input bit pe, input bit po,
                        input bit two, input bit am);
    cfg_div = 16'(dv); cfg_len = 2'(ln); cfg_par_en = pe; cfg_par_odd = po;
    cfg_two_stop = two; cfg_addr_mode = am;
    P = 16 * (dv + 1);
    @(negedge clk);
  endtask

  function automatic int nbits();
    return 5 + int'(cfg_len) + int'(cfg_addr_mode) + int'(cfg_par_en) + 1 + int'(cfg_two_stop);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic a, input bit flip);
    logic [11:0] b = '1;
    logic par = cfg_par_odd ^ flip;
    int n = 5 + int'(cfg_len);
    int p = n;
    for (int i = 0; i < n; i++) begin b[i] = d[i]; par ^= d[i]; end
    if (cfg_addr_mode) begin b[p] = a; par ^= a; p++; end
    if (cfg_par_en) b[p] = par;
    return b;
  endfunction

  task automatic send_rx(input logic [7:0] d, input logic a, input bit flip, input bit bad_stop);
    logic [11:0] b = frame_bits(d, a, flip);
    int n = nbits();
    int s = n - 1 - int'(cfg_two_stop);
    rxd = 0; repeat (P) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == s && bad_stop) begin
        rxd = 0; repeat (P/2 + P/6) @(negedge clk);
        rxd = 1; repeat (P - P/2 - P/6) @(negedge clk);
      end else begin
        rxd = b[k]; repeat (P) @(negedge clk);
      end
    end
    rxd = 1; repeat (P) @(negedge clk);
  endtask

  task automatic rx_expect(input string r, input logic [7:0] d, input logic a,
                           input logic pe, input logic fe, input bit rd);
    chk({r, " rx_valid"}, rx_valid, 1);
    chk({r, " rx_data"}, rx_data, d);
    chk({r, " rx_is_addr"}, rx_is_addr, a);
    chk({r, " rx_perr"}, rx_perr, pe);
    chk({r, " rx_ferr"}, rx_ferr, fe);
    if (rd) begin
      rx_rd = 1; @(negedge clk); rx_rd = 0;
      chk({r, " valid cleared by read"}, rx_valid, 0);
    end
  endtask

  task automatic tx_grab(input bit measure, output logic [11:0] got, output int L);
    int n = nbits();
    got = '0; L = 0;
    while (txd !== 1'b0) @(negedge clk);
    if (measure) begin
      while (txd === 1'b0) begin L++; @(negedge clk); end
      repeat (P/2) @(negedge clk);
    end else begin
      repeat (P + P/2) @(negedge clk);
    end
    for (int k = 0; k < n; k++) begin
      got[k] = txd;
      if (k < n - 1) repeat (P) @(negedge clk);
    end
  endtask

  task automatic write_tx(input logic [7:0] d, input logic a);
    tx_data = d; tx_addr = a; tx_wr = 1; @(negedge clk); tx_wr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] g1, g2, mask;
    int L1, L2, lows;
    repeat (5) @(negedge clk);
    chk("R12 txd idle", txd, 1);
    chk("R12 tx_full", tx_full, 0);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 rx_ovr", rx_ovr, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 txd after release", txd, 1);

    // transmit: 8N1, back-to-back, write while full
    setcfg(2, 3, 0, 0, 0, 0);
    fork
      begin
        write_tx(8'hA5, 0);
        @(negedge clk);
        write_tx(8'h3C, 0);
        write_tx(8'hFF, 0);
        chk("R6 tx_full while queued", tx_full, 1);
      end
      begin
        tx_grab(1, g1, L1);
        tx_grab(0, g2, L2);
      end
    join
    mask = 12'((1 << nbits()) - 1);
    chk("R1 start bit length div=2", L1, P);
    chk("R2 frame A5", g1, frame_bits(8'hA5, 0, 0) & mask);
    chk("R6 second frame 3C in order", g2, frame_bits(8'h3C, 0, 0) & mask);
    lows = 0;
    repeat (20 * P) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk("R6 write while full never sent", lows, 0);
    chk("R6 tx_full empty", tx_full, 0);

    // transmit: 5 bits, address bit, odd parity, two stops, div=0
    setcfg(0, 0, 1, 1, 1, 1);
    fork
      write_tx(8'h13, 1);
      tx_grab(1, g1, L1);
    join
    mask = 12'((1 << nbits()) - 1);
    chk("R1 start bit length div=0", L1, P);
    chk("R3 R4 R5 frame 13 addr odd two-stop", g1, frame_bits(8'h13, 1, 0) & mask);

    // receive: 8N1
    setcfg(2, 3, 0, 0, 0, 0);
    send_rx(8'h5A, 0, 0, 0);
    rx_expect("R8 rx 5A", 8'h5A, 0, 0, 0, 1);

    // receive: 7 bits even parity, upper bit dropped
    setcfg(2, 2, 1, 0, 0, 0);
    send_rx(8'hC1, 0, 0, 0);
    rx_expect("R2 R3 rx 7E1", 8'h41, 0, 0, 0, 1);
    send_rx(8'h41, 0, 1, 0);
    rx_expect("R9 parity error", 8'h41, 0, 1, 0, 1);

    // framing error
    setcfg(2, 3, 0, 0, 0, 0);
    send_rx(8'h81, 0, 0, 1);
    rx_expect("R9 framing error", 8'h81, 0, 0, 1, 1);
    chk("R7 no spurious char after bad stop", rx_valid, 0);

    // two stops, odd parity 6 bits
    setcfg(2, 1, 1, 1, 1, 0);
    send_rx(8'h2D, 0, 0, 0);
    rx_expect("R4 two stop rx", 8'h2D, 0, 0, 0, 1);

    // overrun and interrupt mask
    setcfg(2, 3, 0, 0, 0, 0);
    send_rx(8'h11, 0, 0, 0);
    send_rx(8'h22, 0, 0, 0);
    chk("R8 overrun flag", rx_ovr, 1);
    rx_expect("R8 overrun keeps first", 8'h11, 0, 0, 0, 0);
    int_mask_rx = 1; @(negedge clk);
    chk("R11 masked irq_rx", irq_rx, 0);
    int_mask_rx = 0; @(negedge clk);
    chk("R11 unmasked irq_rx", irq_rx, 1);
    int_mask_tx = 1; @(negedge clk);
    chk("R11 masked irq_tx", irq_tx, 0);
    int_mask_tx = 0;
    rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk("R8 read clears overrun", rx_ovr, 0);
    chk("R8 read clears valid", rx_valid, 0);

    // false start
    rxd = 0; repeat (P/4) @(negedge clk);
    rxd = 1; repeat (2 * P) @(negedge clk);
    chk("R7 short low rejected", rx_valid, 0);
    send_rx(8'h33, 0, 0, 0);
    rx_expect("R7 good frame after glitch", 8'h33, 0, 0, 0, 1);

    // address filtering
    setcfg(2, 3, 0, 0, 0, 1);
    send_rx(8'h11, 0, 0, 0);
    chk("R10 data before any match dropped", rx_valid, 0);
    send_rx(8'h99, 1, 0, 0);
    chk("R10 foreign address dropped", rx_valid, 0);
    send_rx(8'h42, 1, 0, 0);
    rx_expect("R10 own address delivered", 8'h42, 1, 0, 0, 1);
    send_rx(8'h77, 0, 0, 0);
    rx_expect("R10 data after match", 8'h77, 0, 0, 0, 1);
    send_rx(8'h10, 1, 0, 0);
    chk("R10 other address dropped", rx_valid, 0);
    send_rx(8'h55, 0, 0, 0);
    chk("R10 data after other address dropped", rx_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule